// File: doc/BRIEF.md
# Byte Execution Unit with Flags

This block is the data path of a small 8-bit processor core. It combines a 32-entry general-purpose register file, an arithmetic/logic unit and an eight-bit status word. The decoded operation, the destination index and either a source index or an 8-bit literal arrive on each cycle that `valid_i` is high. On the next rising clock edge the result is written into the destination register and the status word is updated.

The unit supports addition and subtraction, each with and without the incoming carry. It also supports AND, OR and XOR, register copy, literal load, and an explicit write of the status word. Literal operands may only target the upper half of the register file. A request that breaks this rule is refused and reported on `err_o`. The status word is exported on `status_o` so that branch logic outside the block can use it. A combinational read port lets the surrounding core, or a bench, observe any register.

Top module: `byte_exec_unit`

## Requirements
- R1: After reset `status_o` is 0x00, `err_o` is 0, and every register reads 0x00.
- R2: Opcode 0 adds, and opcode 1 adds plus the carry (status bit 0). The 8-bit sum is written to the destination register. Status bit 0 takes the carry out of bit 7, bit 5 the carry out of bit 3, bit 3 the signed overflow, bit 2 result bit 7, and bit 1 is set when the result is zero.
- R3: Opcode 2 computes destination minus operand, and opcode 3 also subtracts the carry (status bit 0). Status bit 0 takes the borrow out of bit 7, bit 5 the borrow into bit 4, and bit 3 the signed overflow. Bits 2 and 1 follow the same rule as in R2.
- R4: Opcodes 4, 5 and 6 write the AND, OR and XOR of the destination and the operand. Status bit 3 is cleared, bits 0 and 5 keep their values, and bits 2 and 1 follow the result.
- R5: Opcode 7 copies the source register and opcode 8 loads the literal. Neither opcode changes any status bit.
- R6: Opcode 9 loads all eight status bits from the operand and writes no register. Bit 7 is the interrupt enable and bit 6 is the bit-transfer flag. No other opcode changes bits 7 and 6.
- R7: The operand is `imm_i` when `imm_sel_i` is 1 or the opcode is 8. Such a request is refused when it targets a register below 16 and its opcode is not 9. A refused request sets `err_o` to 1 for the following cycle, writes no register and changes no status bit.
- R8: The register write and the status update happen on the same edge. Right after that edge, `rd_data_o` and later operations see the new value.
- R9: After every arithmetic or logic operation, status bit 4 equals bit 2 XOR bit 3.
- R10: A cycle with `valid_i` low changes no register and no status bit, and `err_o` is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request this cycle |
| op_i | input | 4 | Opcode (0..9) |
| imm_sel_i | input | 1 | Use `imm_i` as the operand |
| dst_i | input | 5 | Destination and first-operand register index |
| src_i | input | 5 | Source register index |
| imm_i | input | 8 | Literal operand |
| rd_idx_i | input | 5 | Observation read index |
| rd_data_o | output | 8 | Contents of register `rd_idx_i` |
| status_o | output | 8 | Status word |
| err_o | output | 1 | Refused literal request in the previous cycle |

## Verification
The assertions check on every cycle the rules that hold no matter what the operands are. These rules are: the sign rule, the clearing of overflow by logic operations, the stability of the flags on copy, load and idle cycles, the protection of the two upper status bits, the status load, and the refusal path. The arithmetic values of the sum, the difference and the carry, half-carry and overflow flags can only be shown by the bench. The bench sweeps a grid of operand pairs under varying carry-in and upper-bit patterns and compares each result with values it computes in integer arithmetic. Directed cases add the boundaries where the refusal rule applies (register 15 against register 16), dependent back-to-back operations, and idle cycles.

// File: rtl/bexu_pkg.sv
package bexu_pkg;
  localparam int unsigned SW = 8;
  localparam int unsigned SB_C  = 0;
  localparam int unsigned SB_Z  = 1;
  localparam int unsigned SB_N  = 2;
  localparam int unsigned SB_V  = 3;
  localparam int unsigned SB_S  = 4;
  localparam int unsigned SB_H  = 5;
  localparam int unsigned SB_BT = 6;
  localparam int unsigned SB_IE = 7;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_MOV = 4'd7,
    OP_LDI = 4'd8,
    OP_WRS = 4'd9
  } bexu_op_e;
endpackage

// File: rtl/bexu_regfile.sv
module bexu_regfile #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned DW    = 8,
  parameter int unsigned NRD   = 3,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           wa_i,
  input  logic [DW-1:0]           wd_i,
  input  logic [NRD-1:0][AW-1:0]  ra_i,
  output logic [NRD-1:0][DW-1:0]  rd_o
);
  logic [DW-1:0] mem_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_o[r] = mem_q[ra_i[r]];
  end

  // R8
  wb_land_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(wa_i)] == $past(wd_i));
endmodule

// File: rtl/bexu_alu.sv
module bexu_alu
  import bexu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  bexu_op_e       op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic [SW-1:0]  st_i,
  output logic [DW-1:0]  res_o,
  output logic [SW-1:0]  st_o,
  output logic           wr_reg_o
);
  localparam int unsigned HB = DW / 2;

  logic          cin;
  logic [DW:0]   sum_w, dif_w;
  logic [HB:0]   sum_lo, dif_lo;
  logic          c_n, h_n, v_n, upd;

  always_comb begin
    cin    = (op_i == OP_ADC || op_i == OP_SBC) ? st_i[SB_C] : 1'b0;
    sum_w  = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin};
    dif_w  = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, cin};
    sum_lo = {1'b0, a_i[HB-1:0]} + {1'b0, b_i[HB-1:0]} + {{HB{1'b0}}, cin};
    dif_lo = {1'b0, a_i[HB-1:0]} - {1'b0, b_i[HB-1:0]} - {{HB{1'b0}}, cin};

    res_o    = a_i;
    st_o     = st_i;
    c_n      = st_i[SB_C];
    h_n      = st_i[SB_H];
    v_n      = 1'b0;
    upd      = 1'b0;
    wr_reg_o = 1'b0;

    case (op_i)
      OP_ADD, OP_ADC: begin
        res_o = sum_w[DW-1:0];
        c_n   = sum_w[DW];
        h_n   = sum_lo[HB];
        v_n   = (a_i[DW-1] == b_i[DW-1]) && (sum_w[DW-1] != a_i[DW-1]);
        upd = 1'b1; wr_reg_o = 1'b1;
      end
      OP_SUB, OP_SBC: begin
        res_o = dif_w[DW-1:0];
        c_n   = dif_w[DW];
        h_n   = dif_lo[HB];
        v_n   = (a_i[DW-1] != b_i[DW-1]) && (dif_w[DW-1] != a_i[DW-1]);
        upd = 1'b1; wr_reg_o = 1'b1;
      end
      OP_AND: begin res_o = a_i & b_i; upd = 1'b1; wr_reg_o = 1'b1; end
      OP_OR:  begin res_o = a_i | b_i; upd = 1'b1; wr_reg_o = 1'b1; end
      OP_XOR: begin res_o = a_i ^ b_i; upd = 1'b1; wr_reg_o = 1'b1; end
      OP_MOV, OP_LDI: begin res_o = b_i; wr_reg_o = 1'b1; end
      OP_WRS: st_o = SW'(b_i);
      default: ;
    endcase

    if (upd) begin
      st_o[SB_C] = c_n;
      st_o[SB_H] = h_n;
      st_o[SB_V] = v_n;
      st_o[SB_N] = res_o[DW-1];
      st_o[SB_Z] = ~|res_o;
      st_o[SB_S] = res_o[DW-1] ^ v_n;
    end
  end
endmodule

// File: rtl/bexu_status.sv
module bexu_status #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/byte_exec_unit.sv
module byte_exec_unit
  import bexu_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic          imm_sel_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] src_i,
  input  logic [DW-1:0] imm_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o,
  output logic [SW-1:0] status_o,
  output logic          err_o
);
  localparam logic [AW-1:0] IMM_LO = AW'(NREGS / 2);

  bexu_op_e              op_e;
  logic [2:0][AW-1:0]    ra;
  logic [2:0][DW-1:0]    rd;
  logic                  imm_use, dst_low, alu_wr, reject, accept;
  logic                  is_logic, is_arlog, is_move;
  logic [DW-1:0]         opnd_b, alu_res;
  logic [SW-1:0]         st_q, st_next;
  logic                  err_q;

  assign op_e     = bexu_op_e'(op_i);
  assign ra       = {rd_idx_i, src_i, dst_i};
  assign imm_use  = imm_sel_i || (op_e == OP_LDI);
  assign dst_low  = dst_i < IMM_LO;
  assign reject   = valid_i && imm_use && dst_low && (op_e != OP_WRS);
  assign accept   = valid_i && !reject;
  assign opnd_b   = imm_use ? imm_i : rd[1];
  assign is_logic = (op_e == OP_AND) || (op_e == OP_OR) || (op_e == OP_XOR);
  assign is_arlog = is_logic || (op_i < 4'd4);
  assign is_move  = (op_e == OP_MOV) || (op_e == OP_LDI);

  bexu_regfile #(.NREGS(NREGS), .DW(DW), .NRD(3)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (accept && alu_wr),
    .wa_i  (dst_i),
    .wd_i  (alu_res),
    .ra_i  (ra),
    .rd_o  (rd)
  );

  bexu_alu #(.DW(DW)) u_alu (
    .op_i    (op_e),
    .a_i     (rd[0]),
    .b_i     (opnd_b),
    .st_i    (st_q),
    .res_o   (alu_res),
    .st_o    (st_next),
    .wr_reg_o(alu_wr)
  );

  bexu_status #(.W(SW)) u_st (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (accept),
    .d_i   (st_next),
    .q_o   (st_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= reject;
  end

  assign rd_data_o = rd[2];
  assign status_o  = st_q;
  assign err_o     = err_q;

  // R7
  reject_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject |=> err_o && $stable(status_o));
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(status_o) && !err_o);
  // R6
  ie_bt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_e != OP_WRS) |=> $stable(status_o[SB_IE:SB_BT]));
  // R6
  status_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op_e == OP_WRS) |=> status_o == $past(SW'(opnd_b)));
  // R9
  sign_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && is_arlog) |=> status_o[SB_S] == (status_o[SB_N] ^ status_o[SB_V]));
  // R4
  logic_v_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && is_logic) |=> !status_o[SB_V] && $stable(status_o[SB_C])
                             && $stable(status_o[SB_H]));
  // R5
  move_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && is_move) |=> $stable(status_o));
endmodule

// File: tb/tb_byte_exec_unit.sv
module tb_byte_exec_unit;
  localparam int ADD = 0, ADC = 1, SUB = 2, SBC = 3, AND_ = 4, OR_ = 5, XOR_ = 6;
  localparam int MOV = 7, LDI = 8, WRS = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, imm_sel = 1'b0;
  logic [3:0] op = '0;
  logic [4:0] dst = '0, src = '0, rd_idx = '0;
  logic [7:0] imm = '0;
  logic [7:0] rd_data, status;
  logic err;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] m_reg [32];
  logic [7:0] m_st;

  always #2 clk = ~clk;

  byte_exec_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .imm_sel_i(imm_sel),
    .dst_i(dst), .src_i(src), .imm_i(imm), .rd_idx_i(rd_idx),
    .rd_data_o(rd_data), .status_o(status), .err_o(err)
  );

  function automatic int sg(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  task automatic check(input string tag, input int d, input bit exp_err);
    rd_idx = 5'(d);
    #1;
    n_run++;
    if (rd_data !== m_reg[d] || status !== m_st || err !== exp_err) begin
      n_fail++;
      $display("FAIL %s: r%0d=%02h exp %02h status=%02h exp %02h err=%0b exp %0b",
               tag, d, rd_data, m_reg[d], status, m_st, err, exp_err);
    end
  endtask

  task automatic run_op(input int o, input int d, input int s, input int iv,
                        input bit sel, input string tag);
    int a, b, cin, res, t, tl, sv;
    bit immu, rej, arl;
    logic [7:0] st;
    immu = sel || (o == LDI);
    a = m_reg[d];
    b = immu ? iv : int'(m_reg[s]);
    rej = immu && (d < 16) && (o != WRS);
    st = m_st;
    res = a;
    arl = 0;
    cin = (o == ADC || o == SBC) ? int'(m_st[0]) : 0;
    if (!rej) begin
      case (o)
        ADD, ADC: begin
          t = a + b + cin; res = t % 256;
          tl = (a % 16) + (b % 16) + cin;
          sv = sg(a) + sg(b) + cin;
          st[0] = t > 255; st[5] = tl > 15; st[3] = (sv > 127 || sv < -128); arl = 1;
        end
        SUB, SBC: begin
          t = a - b - cin; res = (t + 256) % 256;
          tl = (a % 16) - (b % 16) - cin;
          sv = sg(a) - sg(b) - cin;
          st[0] = t < 0; st[5] = tl < 0; st[3] = (sv > 127 || sv < -128); arl = 1;
        end
        AND_: begin res = a & b; st[3] = 0; arl = 1; end
        OR_:  begin res = a | b; st[3] = 0; arl = 1; end
        XOR_: begin res = a ^ b; st[3] = 0; arl = 1; end
        MOV, LDI: res = b;
        WRS: st = 8'(b);
        default: ;
      endcase
      if (arl) begin
        st[2] = res > 127; st[1] = (res == 0); st[4] = st[2] ^ st[3];
      end
      if (o <= LDI) m_reg[d] = 8'(res);
      m_st = st;
    end
    @(negedge clk);
    valid = 1'b1; op = 4'(o); dst = 5'(d); src = 5'(s); imm = 8'(iv); imm_sel = sel;
    @(negedge clk);
    valid = 1'b0;
    check(tag, d, rej);
  endtask

  task automatic idle_check(input int d);
    @(negedge clk);
    valid = 1'b0; op = 4'(ADD); dst = 5'(d); src = 5'(d); imm = 8'h5A; imm_sel = 1'b0;
    @(negedge clk);
    check("R10 idle", d, 1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run still active, expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) m_reg[i] = 8'h00;
    m_st = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state of every register and of the flags
    for (int i = 0; i < 32; i++) check("R1 reset", i, 1'b0);

    // R5 loads and copy; R6 status word write
    run_op(LDI, 16, 0, 8'h7F, 1'b0, "R5 load");
    run_op(LDI, 17, 0, 8'h01, 1'b0, "R5 load");
    run_op(WRS, 0, 0, 8'hC0, 1'b1, "R6 status write");
    run_op(ADD, 16, 17, 0, 1'b0, "R2 add 7F+01");
    run_op(MOV, 20, 16, 0, 1'b0, "R5 copy");
    run_op(LDI, 18, 0, 8'hFF, 1'b0, "R5 load");
    run_op(ADD, 18, 17, 0, 1'b0, "R2 add FF+01 carry zero");
    run_op(ADC, 18, 17, 0, 1'b0, "R8 dependent add with carry");
    run_op(SUB, 18, 16, 0, 1'b0, "R3 sub borrow");
    run_op(SBC, 18, 17, 0, 1'b0, "R8 dependent sub with borrow");
    run_op(WRS, 3, 3, 0, 1'b0, "R6 status from register");

    // R7 refusal at the lower/upper boundary
    run_op(LDI, 5, 0, 8'hAA, 1'b0, "R7 load to r5 refused");
    run_op(ADD, 15, 0, 8'h11, 1'b1, "R7 literal add to r15 refused");
    run_op(AND_, 16, 0, 8'h0F, 1'b1, "R7 literal and to r16 allowed");
    run_op(ADD, 3, 4, 0, 1'b0, "R2 register add to low register");
    run_op(WRS, 2, 0, 8'h3F, 1'b1, "R6 status write with low index");
    run_op(OR_, 2, 16, 0, 1'b0, "R4 or");
    idle_check(16);
    idle_check(2);

    // R2 R3 R4 R9 operand sweep
    for (int ai = 0; ai < 256; ai += 15) begin
      for (int bi = 0; bi < 256; bi += 5) begin
        run_op(LDI, 17, 0, bi, 1'b0, "R5 load b");
        for (int o = 0; o < 7; o++) begin
          run_op(LDI, 16, 0, ai, 1'b0, "R5 load a");
          run_op(WRS, 0, 0, (ai * 7 + bi * 3 + o * 29) % 256, 1'b1, "R6 preset flags");
          if (o < 2)      run_op(o, 16, 17, bi, (bi % 2) == 1, "R2 sweep R9");
          else if (o < 4) run_op(o, 16, 17, bi, (bi % 2) == 1, "R3 sweep R9");
          else            run_op(o, 16, 17, bi, (bi % 2) == 1, "R4 sweep R9");
        end
      end
    end
    idle_check(16);
    finish_run();
  end
endmodule